// File: doc/BRIEF.md
# Consumer-Count Managed Register Cache

This block is a small set-associative store that keeps copies of physical register values beside the execution units. Each cached value carries a 3-bit count of consumers that have not yet read it. Cache reads are served in the same cycle. When a read misses, the requester falls back to the main register file.

The pipeline offers each writeback result together with its predicted use count and the number of consumers that already took it from the bypass network. The block keeps the result only if the reduced count shows that a reader is still pending. Read hits lower the count. A count of 7 means "seven or more" and is never lowered. When a set is full, the entry with the fewest pending consumers is replaced, and ties go to the least recently used way. Commit-time releases remove single entries. A context-switch flush empties the whole cache. Values refilled from the main register file after a miss are installed with a count of zero, so they are the first to be replaced.

Top module: `reg_cache`

## Requirements
- R1: Each read port reports hit or miss in the same cycle. With the port valid and the register present in a valid entry, hit is 1 and the data is the cached value. With the port valid and no matching entry, miss is 1 and the data is 0. An idle port drives both flags low. Reads see the state from before the cycle's updates.
- R2: The set is the low 4 bits of the 7-bit physical register number (default 16 sets). The upper 3 bits form the stored tag, so registers that share a set stay apart.
- R3: A writeback's remaining count is 7 when the predicted count is 7. Otherwise it is the predicted count minus the bypass reads, clamped at 0. A remaining count of 0 leaves the cache unchanged. Any other value is stored with the data.
- R4: A write whose register is already present overwrites that entry in place and never creates a second copy. If the register is not present, the lowest-numbered invalid way is used.
- R5: A release invalidates the valid entry holding that register. A release and a write of the same register in one cycle leave the written value present, because the release is applied first.
- R6: Each read hit lowers the entry's count by one, once per hitting port. A count of 0 stays at 0 and the entry stays valid. A count of 7 is never lowered.
- R7: A flush invalidates every entry, and writes in the flush cycle are dropped. Reads in the flush cycle still see the old contents.
- R8: When a set is full, the victim is the way with the smallest count, with ties broken by least recent use. Both hits and allocations count as uses.
- R9: A miss fill installs the value with a count of 0, after all writeback ports.
- R10: After reset every entry is invalid, so every read misses.
- R11: Writes in one cycle are applied in writeback port order, with the fill last. Each write sees the entries and recency left by the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| flush_i | input | 1 | invalidate all entries (context switch) |
| rd_vld_i | input | RD_PORTS | read request per port |
| rd_tag_i | input | RD_PORTS x PTAG_W | physical register to read |
| rd_hit_o | output | RD_PORTS | read found in cache |
| rd_miss_o | output | RD_PORTS | read not found; use main register file |
| rd_data_o | output | RD_PORTS x DATA_W | cached value, 0 on miss |
| wb_vld_i | input | WB_PORTS | writeback offered |
| wb_tag_i | input | WB_PORTS x PTAG_W | destination physical register |
| wb_data_i | input | WB_PORTS x DATA_W | result value |
| wb_uses_i | input | WB_PORTS x 3 | predicted consumer count (7 = seven or more) |
| wb_byp_i | input | WB_PORTS x 3 | consumers already served by bypass |
| rel_vld_i | input | REL_PORTS | release at commit |
| rel_tag_i | input | REL_PORTS x PTAG_W | released physical register |
| fill_vld_i | input | 1 | refill after a miss |
| fill_tag_i | input | PTAG_W | refilled physical register |
| fill_data_i | input | DATA_W | refilled value |

## Verification
The bench drives sets into conflict and targets these corner cases:
- The order of two same-cycle allocations into one set. A design that ignored port order would evict the wrong register.
- Two ports hitting one entry in the same cycle. A design that decremented only once would keep a count of one, so LRU would pick a different victim.
- A saturated count that must survive repeated reads, and a zero count that must not wrap to 7.
- A release that collides with a write of the same register. Applying the release second would lose the new value.
- Refilled entries, which must go first even when just touched.
- Rewrites of a present register. A design that duplicated it would return stale data from the lower way.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
endpackage

// File: rtl/rc_wb_filter.sv
module rc_wb_filter import rc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] uses_i,
  input  logic [CNT_W-1:0] byp_i,
  output logic             go_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] left;

  always_comb begin
    if (uses_i == CNT_SAT)    left = CNT_SAT;
    else if (uses_i > byp_i)  left = uses_i - byp_i;
    else                      left = '0;
  end

  assign go_o  = vld_i && (left != '0);
  assign cnt_o = left;

  assert_sat_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && uses_i == CNT_SAT) |-> (go_o && cnt_o == CNT_SAT));
  assert_no_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && uses_i != CNT_SAT && uses_i <= byp_i) |-> !go_o);
endmodule

// File: rtl/rc_read_port.sv
module rc_read_port #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 1
) (
  input  logic                        vld_i,
  input  logic [TAG_W-1:0]            key_i,
  input  logic [WAYS-1:0]             row_vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag_i,
  input  logic [WAYS-1:0][DATA_W-1:0] row_data_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [DATA_W-1:0]           data_o
);
  // descending scan: lowest matching way wins
  always_comb begin
    hit_o  = 1'b0;
    way_o  = '0;
    data_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_i && row_vld_i[w] && row_tag_i[w] == key_i) begin
        hit_o  = 1'b1;
        way_o  = WAY_W'(w);
        data_o = row_data_i[w];
      end
    end
  end
endmodule

// File: rtl/reg_cache.sv
module reg_cache import rc_pkg::*; #(
  parameter int NUM_PREGS = 128,
  parameter int ENTRIES   = 32,
  parameter int WAYS      = 2,
  parameter int DATA_W    = 32,
  parameter int RD_PORTS  = 4,
  parameter int WB_PORTS  = 4,
  parameter int REL_PORTS = 2,
  localparam int PTAG_W   = $clog2(NUM_PREGS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                flush_i,
  input  logic [RD_PORTS-1:0]                 rd_vld_i,
  input  logic [RD_PORTS-1:0][PTAG_W-1:0]     rd_tag_i,
  output logic [RD_PORTS-1:0]                 rd_hit_o,
  output logic [RD_PORTS-1:0]                 rd_miss_o,
  output logic [RD_PORTS-1:0][DATA_W-1:0]     rd_data_o,
  input  logic [WB_PORTS-1:0]                 wb_vld_i,
  input  logic [WB_PORTS-1:0][PTAG_W-1:0]     wb_tag_i,
  input  logic [WB_PORTS-1:0][DATA_W-1:0]     wb_data_i,
  input  logic [WB_PORTS-1:0][CNT_W-1:0]      wb_uses_i,
  input  logic [WB_PORTS-1:0][CNT_W-1:0]      wb_byp_i,
  input  logic [REL_PORTS-1:0]                rel_vld_i,
  input  logic [REL_PORTS-1:0][PTAG_W-1:0]    rel_tag_i,
  input  logic                                fill_vld_i,
  input  logic [PTAG_W-1:0]                   fill_tag_i,
  input  logic [DATA_W-1:0]                   fill_data_i
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = PTAG_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W = WAY_W;
  localparam int NSRC  = WB_PORTS + 1;

  typedef logic [WAYS-1:0][AGE_W-1:0] age_row_t;

  logic [WAYS-1:0]             vld_q  [SETS], vld_d  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS], tag_d  [SETS];
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q  [SETS], cnt_d  [SETS];
  age_row_t                    age_q  [SETS], age_d  [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q [SETS], data_d [SETS];

  // age 0 = most recent; ages in a set stay a permutation
  function automatic age_row_t touch(input age_row_t a, input int w);
    age_row_t r = a;
    for (int i = 0; i < WAYS; i++)
      if (a[i] < a[w]) r[i] = a[i] + 1'b1;
    r[w] = '0;
    return r;
  endfunction

  function automatic int pick_way(input logic [WAYS-1:0] v,
                                  input logic [WAYS-1:0][TAG_W-1:0] t,
                                  input logic [WAYS-1:0][CNT_W-1:0] c,
                                  input age_row_t a,
                                  input logic [TAG_W-1:0] key);
    int  w = 0;
    logic found = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (!found && v[i] && t[i] == key) begin w = i; found = 1'b1; end
    for (int i = 0; i < WAYS; i++)
      if (!found && !v[i]) begin w = i; found = 1'b1; end
    if (!found)
      for (int i = 1; i < WAYS; i++)
        if (c[i] < c[w] || (c[i] == c[w] && a[i] > a[w])) w = i;
    return w;
  endfunction

  // ---- read ports ----
  logic [RD_PORTS-1:0]            hit;
  logic [RD_PORTS-1:0][WAY_W-1:0] hit_way;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [SET_W-1:0] rs;
    assign rs = rd_tag_i[p][SET_W-1:0];
    rc_read_port #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAY_W(WAY_W)) u_rd (
      .vld_i      (rd_vld_i[p]),
      .key_i      (rd_tag_i[p][PTAG_W-1:SET_W]),
      .row_vld_i  (vld_q[rs]),
      .row_tag_i  (tag_q[rs]),
      .row_data_i (data_q[rs]),
      .hit_o      (hit[p]),
      .way_o      (hit_way[p]),
      .data_o     (rd_data_o[p])
    );
    assign rd_hit_o[p]  = hit[p];
    assign rd_miss_o[p] = rd_vld_i[p] & ~hit[p];
  end

  // ---- write sources: writeback ports then fill ----
  logic [NSRC-1:0]             src_go;
  logic [NSRC-1:0][CNT_W-1:0]  src_cnt;
  logic [NSRC-1:0][PTAG_W-1:0] src_tag;
  logic [NSRC-1:0][DATA_W-1:0] src_data;

  for (genvar k = 0; k < WB_PORTS; k++) begin : g_wb
    rc_wb_filter u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (wb_vld_i[k]),
      .uses_i (wb_uses_i[k]),
      .byp_i  (wb_byp_i[k]),
      .go_o   (src_go[k]),
      .cnt_o  (src_cnt[k])
    );
    assign src_tag[k]  = wb_tag_i[k];
    assign src_data[k] = wb_data_i[k];
  end
  assign src_go[NSRC-1]   = fill_vld_i;
  assign src_cnt[NSRC-1]  = '0;
  assign src_tag[NSRC-1]  = fill_tag_i;
  assign src_data[NSRC-1] = fill_data_i;

  // ---- next state: read decrements, releases, writes in order, flush ----
  always_comb begin
    logic [SET_W-1:0] s;
    int w;
    s = '0;
    w = 0;
    vld_d = vld_q; tag_d = tag_q; cnt_d = cnt_q; age_d = age_q; data_d = data_q;
    for (int p = 0; p < RD_PORTS; p++) begin
      if (hit[p]) begin
        s = rd_tag_i[p][SET_W-1:0];
        w = int'(hit_way[p]);
        if (cnt_d[s][w] != '0 && cnt_d[s][w] != CNT_SAT)
          cnt_d[s][w] = cnt_d[s][w] - 1'b1;
        age_d[s] = touch(age_d[s], w);
      end
    end
    for (int r = 0; r < REL_PORTS; r++) begin
      if (rel_vld_i[r]) begin
        s = rel_tag_i[r][SET_W-1:0];
        for (int i = 0; i < WAYS; i++)
          if (vld_d[s][i] && tag_d[s][i] == rel_tag_i[r][PTAG_W-1:SET_W])
            vld_d[s][i] = 1'b0;
      end
    end
    for (int k = 0; k < NSRC; k++) begin
      if (src_go[k]) begin
        s = src_tag[k][SET_W-1:0];
        w = pick_way(vld_d[s], tag_d[s], cnt_d[s], age_d[s], src_tag[k][PTAG_W-1:SET_W]);
        vld_d[s][w]  = 1'b1;
        tag_d[s][w]  = src_tag[k][PTAG_W-1:SET_W];
        cnt_d[s][w]  = src_cnt[k];
        data_d[s][w] = src_data[k];
        age_d[s]     = touch(age_d[s], w);
      end
    end
    if (flush_i)
      for (int i = 0; i < SETS; i++) vld_d[i] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i]  <= '0;
        tag_q[i]  <= '0;
        cnt_q[i]  <= '0;
        data_q[i] <= '0;
        for (int j = 0; j < WAYS; j++) age_q[i][j] <= AGE_W'(j);
      end
    end else begin
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      cnt_q  <= cnt_d;
      age_q  <= age_d;
      data_q <= data_d;
    end
  end

  // ---- assertions ----
  function automatic logic present(input logic [PTAG_W-1:0] pr);
    logic res = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (vld_q[pr[SET_W-1:0]][i] && tag_q[pr[SET_W-1:0]][i] == pr[PTAG_W-1:SET_W])
        res = 1'b1;
    return res;
  endfunction

  logic any_vld, dup_tag;
  always_comb begin
    any_vld = 1'b0;
    dup_tag = 1'b0;
    for (int i = 0; i < SETS; i++)
      for (int a = 0; a < WAYS; a++) begin
        any_vld |= vld_q[i][a];
        for (int b = a + 1; b < WAYS; b++)
          if (vld_q[i][a] && vld_q[i][b] && tag_q[i][a] == tag_q[i][b]) dup_tag = 1'b1;
      end
  end

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_vld);
  assert_no_duplicate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_tag);
  assert_fill_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_vld_i && !flush_i) |=> present($past(fill_tag_i)));

  for (genvar r = 0; r < REL_PORTS; r++) begin : g_rel_chk
    logic rel_alone;
    always_comb begin
      rel_alone = 1'b1;
      for (int k = 0; k < NSRC; k++)
        if (src_go[k] && src_tag[k] == rel_tag_i[r]) rel_alone = 1'b0;
    end
    assert_release_gone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_vld_i[r] && rel_alone) |=> !present($past(rel_tag_i[r])));
  end
endmodule

// File: tb/reg_cache_test.sv
module reg_cache_test;
  localparam int SETS = 16, WAYS = 2, RDP = 4, WBP = 4, RELP = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [RDP-1:0] rd_vld, rd_hit, rd_miss;
  logic [RDP-1:0][6:0] rd_tag;
  logic [RDP-1:0][31:0] rd_data;
  logic [WBP-1:0] wb_vld;
  logic [WBP-1:0][6:0] wb_tag;
  logic [WBP-1:0][31:0] wb_data;
  logic [WBP-1:0][2:0] wb_uses, wb_byp;
  logic [RELP-1:0] rel_vld;
  logic [RELP-1:0][6:0] rel_tag;
  logic fill_vld;
  logic [6:0] fill_tag;
  logic [31:0] fill_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reg_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .rd_vld_i(rd_vld), .rd_tag_i(rd_tag), .rd_hit_o(rd_hit), .rd_miss_o(rd_miss), .rd_data_o(rd_data),
    .wb_vld_i(wb_vld), .wb_tag_i(wb_tag), .wb_data_i(wb_data), .wb_uses_i(wb_uses), .wb_byp_i(wb_byp),
    .rel_vld_i(rel_vld), .rel_tag_i(rel_tag),
    .fill_vld_i(fill_vld), .fill_tag_i(fill_tag), .fill_data_i(fill_data)
  );

  // behavioural model: last-use timestamps instead of ages
  bit     mv [SETS][WAYS];
  int     mt [SETS][WAYS];
  int     mc [SETS][WAYS];
  longint md [SETS][WAYS];
  longint ms [SETS][WAYS];
  longint stamp = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mfind(input int pr, output int w);
    w = 0;
    for (int i = 0; i < WAYS; i++)
      if (mv[pr % SETS][i] && mt[pr % SETS][i] == pr) begin w = i; return 1; end
    return 0;
  endfunction

  function automatic int mchoose(input int pr);
    int s = pr % SETS, w = 0;
    if (mfind(pr, w)) return w;
    for (int i = 0; i < WAYS; i++) if (!mv[s][i]) return i;
    for (int i = 1; i < WAYS; i++)
      if (mc[s][i] < mc[s][w] || (mc[s][i] == mc[s][w] && ms[s][i] < ms[s][w])) w = i;
    return w;
  endfunction

  task automatic idle();
    flush = 0; rd_vld = '0; rd_tag = '0; wb_vld = '0; wb_tag = '0; wb_data = '0;
    wb_uses = '0; wb_byp = '0; rel_vld = '0; rel_tag = '0;
    fill_vld = 0; fill_tag = '0; fill_data = '0;
  endtask

  // inputs set after a negedge; compare, advance model, move to next negedge
  task automatic tick();
    #2;
    for (int p = 0; p < RDP; p++) begin
      int w = 0;
      bit h = rd_vld[p] && mfind(int'(rd_tag[p]), w);
      chk(rd_hit[p] == h, "R1 hit", rd_hit[p], h);
      chk(rd_miss[p] == (rd_vld[p] && !h), "R1 miss", rd_miss[p], rd_vld[p] && !h);
      chk(rd_data[p] == (h ? md[rd_tag[p] % SETS][w] : 0), "R1 data", rd_data[p],
          h ? md[rd_tag[p] % SETS][w] : 0);
    end
    for (int p = 0; p < RDP; p++) begin
      int w = 0;
      if (rd_vld[p] && mfind(int'(rd_tag[p]), w)) begin
        int s = rd_tag[p] % SETS;
        if (mc[s][w] != 0 && mc[s][w] != 7) mc[s][w]--;
        stamp++; ms[s][w] = stamp;
      end
    end
    for (int r = 0; r < RELP; r++) begin
      int w = 0;
      if (rel_vld[r] && mfind(int'(rel_tag[r]), w)) mv[rel_tag[r] % SETS][w] = 0;
    end
    for (int k = 0; k <= WBP; k++) begin
      bit go; int c, pr; longint dv;
      if (k < WBP) begin
        c  = (wb_uses[k] == 7) ? 7 : (wb_uses[k] > wb_byp[k] ? wb_uses[k] - wb_byp[k] : 0);
        go = wb_vld[k] && c != 0; pr = wb_tag[k]; dv = wb_data[k];
      end else begin
        c = 0; go = fill_vld; pr = fill_tag; dv = fill_data;
      end
      if (go) begin
        int s = pr % SETS, w = mchoose(pr);
        mv[s][w] = 1; mt[s][w] = pr; mc[s][w] = c; md[s][w] = dv;
        stamp++; ms[s][w] = stamp;
      end
    end
    if (flush) foreach (mv[i, j]) mv[i][j] = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic wb(input int k, input int pr, input int dv, input int u, input int b);
    wb_vld[k] = 1; wb_tag[k] = 7'(pr); wb_data[k] = 32'(dv); wb_uses[k] = 3'(u); wb_byp[k] = 3'(b);
  endtask

  task automatic exp_read(input int pr, input bit eh, input int ed, input string req);
    rd_vld[0] = 1; rd_tag[0] = 7'(pr);
    #2;
    chk(rd_hit[0] == eh, req, rd_hit[0], eh);
    if (eh) chk(rd_data[0] == 32'(ed), req, rd_data[0], ed);
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    foreach (mv[i, j]) mv[i][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: empty after reset
    exp_read(2, 0, 0, "R10 empty");
    exp_read(21, 0, 0, "R10 empty");
    // R3: 3 uses minus 1 bypass -> count 2; R6 floor at 0 keeps entry
    wb(0, 2, 'hA2, 3, 1); tick();
    exp_read(2, 1, 'hA2, "R3 cached");
    exp_read(2, 1, 'hA2, "R6 decrement");
    exp_read(2, 1, 'hA2, "R6 zero stays valid");
    // R3: no pending consumers -> not cached
    wb(0, 18, 'h18, 2, 2); tick();
    exp_read(18, 0, 0, "R3 zero not cached");
    wb(0, 34, 'h34, 1, 3); tick();
    exp_read(34, 0, 0, "R3 clamp not cached");
    // R4: rewrite in place, no stale copy
    wb(0, 2, 'hB2, 1, 0); tick();
    exp_read(2, 1, 'hB2, "R4 overwrite in place");
    // R6 saturation, R8 fewest-count victim (set 5)
    wb(0, 21, 'h21, 7, 3); tick();
    for (int i = 0; i < 9; i++) exp_read(21, 1, 'h21, "R6 saturated kept");
    wb(0, 37, 'h37, 1, 0); tick();
    wb(0, 53, 'h53, 2, 0); tick();
    exp_read(37, 0, 0, "R8 fewest evicted");
    exp_read(21, 1, 'h21, "R8 saturated survives");
    exp_read(53, 1, 'h53, "R8 new entry");
    // R11/R8: same-cycle order sets recency; tie goes to LRU (set 6)
    wb(0, 6, 'h06, 7, 0); wb(1, 22, 'h22, 7, 0); tick();
    wb(0, 38, 'h38, 7, 0); tick();
    exp_read(6, 0, 0, "R11 earlier port is LRU");
    exp_read(22, 1, 'h22, "R11 later port kept");
    // R5: release, then release colliding with write
    rel_vld[0] = 1; rel_tag[0] = 38; tick();
    exp_read(38, 0, 0, "R5 released");
    rel_vld[1] = 1; rel_tag[1] = 22; wb(0, 22, 'hC2, 7, 0); tick();
    exp_read(22, 1, 'hC2, "R5 release before write");
    // R9: fill with zero count is first victim
    fill_vld = 1; fill_tag = 70; fill_data = 'h70; tick();
    exp_read(70, 1, 'h70, "R9 fill present");
    wb(0, 86, 'h86, 7, 0); tick();
    exp_read(70, 0, 0, "R9 fill evicted first");
    exp_read(22, 1, 'hC2, "R9 other kept");
    // R2: two registers of set 3 kept apart
    wb(0, 3, 'h03, 7, 0); wb(1, 19, 'h19, 7, 0); tick();
    exp_read(3, 1, 'h03, "R2 set 3 way");
    exp_read(19, 1, 'h19, "R2 set 3 other tag");
    exp_read(4, 0, 0, "R2 other set untouched");
    // R6: two ports hitting one entry decrement twice
    wb(0, 10, 'h10, 2, 0); tick();
    wb(0, 26, 'h26, 1, 0); tick();
    rd_vld[1:0] = 2'b11; rd_tag[0] = 10; rd_tag[1] = 10;
    #2;
    chk(rd_hit[0] && rd_hit[1], "R6 dual hit", {rd_hit[1], rd_hit[0]}, 3);
    tick();
    wb(0, 42, 'h42, 7, 0); tick();
    exp_read(10, 0, 0, "R6 double decrement");
    exp_read(26, 1, 'h26, "R6 LRU not used");
    // R7: flush drops same-cycle write, reads see old state
    flush = 1; wb(0, 9, 'h09, 7, 0);
    rd_vld[0] = 1; rd_tag[0] = 22;
    #2;
    chk(rd_hit[0] == 1, "R7 read during flush", rd_hit[0], 1);
    tick();
    exp_read(22, 0, 0, "R7 flushed");
    exp_read(9, 0, 0, "R7 write dropped");
    exp_read(3, 0, 0, "R7 flushed");
    // random traffic against model
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < RDP; p++) begin
        rd_vld[p] = ($urandom % 2) == 0;
        rd_tag[p] = 7'((($urandom % 6) << 4) | ($urandom % 3));
      end
      for (int k = 0; k < WBP; k++)
        if ($urandom % 10 < 3)
          wb(k, int'((($urandom % 6) << 4) | ($urandom % 3)), int'($urandom), int'($urandom % 8), int'($urandom % 4));
      for (int r = 0; r < RELP; r++) begin
        rel_vld[r] = ($urandom % 10) == 0;
        rel_tag[r] = 7'((($urandom % 6) << 4) | ($urandom % 3));
      end
      fill_vld = ($urandom % 10) == 0;
      fill_tag = 7'((($urandom % 6) << 4) | ($urandom % 3));
      fill_data = $urandom;
      flush = ($urandom % 100) == 0;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule